// File: doc/BRIEF.md
# Two-Channel Compare-Match Timer

This peripheral provides two independent interval timers behind a small synchronous register port. Each channel owns an up-counter, a limit (compare) register and a control/status register. The counter advances on a tick that a per-channel prescaler derives from the bus clock. When the count arrives at the limit, the channel raises its match flag, and the next tick returns the counter to zero. A channel's interrupt line is high while its match flag and its interrupt enable are both set.

Software starts and stops the channels through one shared run register, which holds one bit per channel. It clears a pending match by rewriting the control register with the flag bit at 0. A new count value written by software does not take effect at once. It passes through a two-step synchronisation, and until it lands, reads keep returning the old count.

The register port is 16 bits wide and addressed by halfword index. Reads are combinational from the current register state. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `cmt_timer`

## Requirements
- R1: After reset the run register reads 0, each control register reads 0, each counter reads 0, each limit register reads 0xFFFF and both interrupt lines are low.
- R2: Halfword index 0 is the run register. Channel c uses index 1+3c for control, 2+3c for counter and 3+3c for limit. In the control register only bit 7 (flag), bit 6 (enable) and bits 1:0 (divide code) are implemented. Every other bit, and every other index, reads 0.
- R3: Bit c of the run register lets channel c count. While that bit is 0 the channel's counter holds its value, whatever the other channel is doing. The run register reads back as written.
- R4: Divide code k in control bits 1:0 gives one tick every 8·4^k bus clocks (k=0..3 → 8, 32, 128, 512). The prescaler is held at zero while the channel is stopped, so the first count arrives exactly 8·4^k clocks after the edge that sets the run bit.
- R5: The counter steps 0,1,…,limit,0 on successive ticks. The flag (bit 7) sets on the tick on which the counter becomes equal to the limit, so successive flag sets are (limit+1) ticks apart.
- R6: Interrupt line c is high exactly while channel c's flag and enable (bit 6) are both 1, and stays high until the flag is cleared.
- R7: A control write with bit 7 at 0 clears the flag. A control write with bit 7 at 1 leaves the flag unchanged and never sets it. Bits 6 and 1:0 take the written value.
- R8: On a running channel, a counter write lands on the second tick after the write. Until then the counter keeps counting from its old value, and on the following tick it counts on from the written value.
- R9: On a stopped channel, a counter write lands two clock cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 3 | Halfword register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 2 | Per-channel match interrupt |

## Verification
On every cycle the assertions check the following. A flag can only rise on a count tick, and the counter then equals the limit. A stopped channel's counter holds. A counter write never changes the count on its own edge. No tick comes in the cycle right after a start. The exact periods under each divide code, the limit+1 spacing of matches, the two-tick and two-cycle landing of counter writes, and the flag's read, clear and write-one behaviour depend on end-to-end cycle counts. Only the bench's timed scenarios can show those.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CKS_W    = 2;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_LIMIT = 2'd2
    } chan_reg_e;

    // halfword index of a channel register; index 0 is the run register
    function automatic int reg_index(int ch, chan_reg_e sel);
        return 1 + 3 * ch + int'(sel);
    endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int DIV_BASE_LOG2 = 3,
    parameter int DIV_STEP_LOG2 = 2,
    parameter int CKS_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    localparam int PW = DIV_BASE_LOG2 + DIV_STEP_LOG2 * ((1 << CKS_W) - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] last;

    always_comb begin
        last  = PW'((1 << (DIV_BASE_LOG2 + DIV_STEP_LOG2 * int'(cks))) - 1);
        tick  = run && (pre_q >= last);
        pre_d = pre_q + 1'b1;
        if (!run || tick) pre_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_NO_TICK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !tick); // R4
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int DW            = 16,
    parameter int DIV_BASE_LOG2 = 3,
    parameter int DIV_STEP_LOG2 = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_ctrl,
    input  logic          wr_count,
    input  logic          wr_limit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_rd,
    output logic [DW-1:0] count_rd,
    output logic [DW-1:0] limit_rd,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0]    cnt;
        logic [DW-1:0]    cmp;
        logic [DW-1:0]    pval;
        logic             pend;
        logic             age;
        logic             flag;
        logic             ie;
        logic [CKS_W-1:0] cks;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic          tick, step, load, match;
    logic [DW-1:0] nxt;

    cmt_prescaler #(
        .DIV_BASE_LOG2(DIV_BASE_LOG2),
        .DIV_STEP_LOG2(DIV_STEP_LOG2),
        .CKS_W        (CKS_W)
    ) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .cks  (s_q.cks),
        .tick (tick)
    );

    always_comb begin
        s_d   = s_q;
        step  = run ? tick : 1'b1;
        load  = s_q.pend && step && s_q.age;
        nxt   = (s_q.cnt == s_q.cmp) ? '0 : s_q.cnt + 1'b1;
        match = tick && !load && (nxt == s_q.cmp);

        if (s_q.pend && step) s_d.age = 1'b1;
        if (load) begin
            s_d.cnt  = s_q.pval;
            s_d.pend = 1'b0;
            s_d.age  = 1'b0;
        end else if (tick) begin
            s_d.cnt = nxt;
        end

        if (wr_ctrl) begin
            s_d.ie   = wdata[IE_BIT];
            s_d.cks  = wdata[CKS_W-1:0];
            s_d.flag = s_q.flag & wdata[FLAG_BIT];
        end
        if (match) s_d.flag = 1'b1;

        if (wr_count) begin
            s_d.pval = wdata;
            s_d.pend = 1'b1;
            s_d.age  = 1'b0;
        end
        if (wr_limit) s_d.cmp = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[FLAG_BIT] = s_q.flag;
        ctrl_rd[IE_BIT]   = s_q.ie;
        ctrl_rd[CKS_W-1:0] = s_q.cks;
        count_rd          = s_q.cnt;
        limit_rd          = s_q.cmp;
        irq               = s_q.flag && s_q.ie;
    end

    AST_FLAG_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(tick)); // R7
    AST_MATCH_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.flag) && $stable(s_q.cmp)) |-> (s_q.cnt == s_q.cmp)); // R5
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !s_q.pend && !wr_count) |=> $stable(s_q.cnt)); // R3
    AST_WRITE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count && !tick && !s_q.pend) |=> $stable(s_q.cnt)); // R8
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NCH           = 2,
    parameter int DW            = 16,
    parameter int DIV_BASE_LOG2 = 3,
    parameter int DIV_STEP_LOG2 = 2,
    localparam int AW           = $clog2(1 + 3 * NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    logic [NCH-1:0] run_d, run_q;
    logic           wr_en;
    logic [DW-1:0]  ctrl_rd  [NCH];
    logic [DW-1:0]  count_rd [NCH];
    logic [DW-1:0]  limit_rd [NCH];

    assign wr_en = bus_sel && bus_wr;

    always_comb begin
        run_d = run_q;
        if (wr_en && bus_addr == '0) run_d = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cmt_channel #(
            .DW           (DW),
            .DIV_BASE_LOG2(DIV_BASE_LOG2),
            .DIV_STEP_LOG2(DIV_STEP_LOG2)
        ) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q[c]),
            .wr_ctrl (wr_en && bus_addr == AW'(reg_index(c, SEL_CTRL))),
            .wr_count(wr_en && bus_addr == AW'(reg_index(c, SEL_COUNT))),
            .wr_limit(wr_en && bus_addr == AW'(reg_index(c, SEL_LIMIT))),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_rd[c]),
            .count_rd(count_rd[c]),
            .limit_rd(limit_rd[c]),
            .irq     (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = DW'(run_q);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(reg_index(c, SEL_CTRL)))  bus_rdata = ctrl_rd[c];
            if (bus_addr == AW'(reg_index(c, SEL_COUNT))) bus_rdata = count_rd[c];
            if (bus_addr == AW'(reg_index(c, SEL_LIMIT))) bus_rdata = limit_rd[c];
        end
    end
endmodule

// File: tb/test_cmt_timer.sv
module test_cmt_timer;
    localparam int CLK_P = 10;
    localparam logic [2:0] A_RUN = 3'd0, A_CSR0 = 3'd1, A_CNT0 = 3'd2, A_CMP0 = 3'd3,
                           A_CSR1 = 3'd4, A_CNT1 = 3'd5, A_CMP1 = 3'd6, A_NONE = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic [1:0]  irq;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cmt_timer i_cmt_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, old, other;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_RUN, v);  chk("R1 run", v, 16'h0);
        rd(A_CSR0, v); chk("R1 ctrl0", v, 16'h0);
        rd(A_CNT0, v); chk("R1 count0", v, 16'h0);
        rd(A_CMP0, v); chk("R1 limit0", v, 16'hFFFF);
        rd(A_CSR1, v); chk("R1 ctrl1", v, 16'h0);
        rd(A_CNT1, v); chk("R1 count1", v, 16'h0);
        rd(A_CMP1, v); chk("R1 limit1", v, 16'hFFFF);
        chk("R1 irq", 32'(irq), 32'h0);

        // R3 run register readback
        wr(A_RUN, 16'h0003); rd(A_RUN, v); chk("R3 run readback", v, 16'h0003);
        wr(A_RUN, 16'h0000);

        // R4 sweep over divide codes, channel 0; R3 channel 1 stays still
        wr(A_CNT1, 16'h0055);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            int s, guard;
            wr(A_RUN, 16'h0000);
            wr(A_CSR0, 16'(k));
            wr(A_CNT0, 16'h0000);
            repeat (3) @(negedge clk);
            wr(A_RUN, 16'h0001);
            s = cyc;
            guard = 0;
            rd(A_CNT0, v);
            while (v == 16'h0 && guard < 2000) begin
                @(negedge clk);
                guard++;
                rd(A_CNT0, v);
            end
            chk("R4 first tick delay", 32'(cyc - s), 32'(8 << (2 * k)));
            rd(A_CNT1, v); chk("R3 stopped channel holds", v, 16'h0055);
        end
        wr(A_RUN, 16'h0000);

        // R5/R6 match period on channel 1, divide by 8, several limits
        for (int i = 0; i < 4; i++) begin
            int lim, r1, r2, r3, guard;
            lim = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 3 : 6;
            wr(A_RUN, 16'h0000);
            wr(A_CNT1, 16'h0000);
            wr(A_CMP1, 16'(lim));
            wr(A_CSR1, 16'h0040);
            repeat (2) @(negedge clk);
            rd(A_CNT0, other);
            wr(A_RUN, 16'h0002);
            r1 = 0; r2 = 0; r3 = 0;
            for (int n = 0; n < 3; n++) begin
                guard = 0;
                while (!irq[1] && guard < 3000) begin @(negedge clk); guard++; end
                rd(A_CNT1, v);
                chk("R5 counter at limit when flag sets", v, 16'(lim));
                if (n == 0) r1 = cyc; else if (n == 1) r2 = cyc; else r3 = cyc;
                wr(A_CSR1, 16'h0040);
                chk("R6 irq drops after clear", 32'(irq[1]), 32'h0);
            end
            chk("R5 match spacing a", 32'(r2 - r1), 32'(8 * (lim + 1)));
            chk("R5 match spacing b", 32'(r3 - r2), 32'(8 * (lim + 1)));
            rd(A_CNT0, v); chk("R3 channel 0 unaffected", v, other);
        end
        wr(A_RUN, 16'h0000);

        // R6/R7 flag, enable and clearing on channel 0
        wr(A_CNT0, 16'h0000);
        wr(A_CMP0, 16'h0003);
        wr(A_CSR0, 16'h0000);
        repeat (3) @(negedge clk);
        wr(A_RUN, 16'h0001);
        repeat (45) @(negedge clk);
        wr(A_RUN, 16'h0000);
        rd(A_CSR0, v); chk("R5 flag set after match", v, 16'h0080);
        chk("R6 irq low when disabled", 32'(irq[0]), 32'h0);
        wr(A_CSR0, 16'h00C0);
        rd(A_CSR0, v); chk("R7 write one keeps flag", v, 16'h00C0);
        chk("R6 irq high with flag and enable", 32'(irq[0]), 32'h1);
        repeat (5) @(negedge clk);
        chk("R6 irq held", 32'(irq[0]), 32'h1);
        wr(A_CSR0, 16'h0040);
        rd(A_CSR0, v); chk("R7 write zero clears", v, 16'h0040);
        chk("R6 irq low after clear", 32'(irq[0]), 32'h0);
        wr(A_CSR0, 16'h00C3);
        rd(A_CSR0, v); chk("R7 write one never sets", v, 16'h0043);
        wr(A_CSR0, 16'hFFFF);
        rd(A_CSR0, v); chk("R2 unimplemented bits zero", v, 16'h0043);
        rd(A_NONE, v); chk("R2 unused index zero", v, 16'h0000);
        wr(A_CMP0, 16'hABCD);
        rd(A_CMP0, v); chk("R2 limit readback", v, 16'hABCD);
        rd(A_CMP1, v); chk("R2 limit1 independent", v, 16'h0006);

        // R8 deferred counter write while running
        begin
            int w, guard;
            wr(A_CSR0, 16'h0000);
            wr(A_CMP0, 16'hFFFF);
            wr(A_CNT0, 16'h0100);
            repeat (3) @(negedge clk);
            wr(A_RUN, 16'h0001);
            rd(A_CNT0, old);
            guard = 0;
            rd(A_CNT0, v);
            while (v == old && guard < 100) begin @(negedge clk); guard++; rd(A_CNT0, v); end
            old = v;
            wr(A_CNT0, 16'h1234);
            w = cyc;
            repeat (14) @(negedge clk);
            rd(A_CNT0, v); chk("R8 old count before second tick", v, old + 16'd1);
            @(negedge clk);
            rd(A_CNT0, v); chk("R8 written value on second tick", v, 16'h1234);
            repeat (8) @(negedge clk);
            rd(A_CNT0, v); chk("R8 counting resumes", v, 16'h1235);
            chk("R8 timing base", 32'(cyc - w), 32'd23);
        end

        // R9 counter write while stopped
        wr(A_RUN, 16'h0000);
        rd(A_CNT0, old);
        wr(A_CNT0, 16'h0042);
        rd(A_CNT0, v); chk("R9 unchanged at write edge", v, old);
        @(negedge clk);
        rd(A_CNT0, v); chk("R9 unchanged one cycle later", v, old);
        @(negedge clk);
        rd(A_CNT0, v); chk("R9 landed after two cycles", v, 16'h0042);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule